// File: doc/BRIEF.md
# Prescaled Up-Counting Time Base with Staged Reload

This block is the time base of a timer. It divides its clock by a programmable factor and drives a main counter that climbs from zero to a reload limit and then starts over. Each wrap produces an update event: a one-cycle pulse on the output and a sticky interrupt flag that stays set until software clears it.

The divide factor and the reload limit are each written into a staging register. The staged value can be read back at once, but the counter keeps running with the active copy. The active copy is refreshed only when an update event occurs. Software can force an update event through a request bit. That event also returns the counter and the divider to zero. An update-block control bit makes this request do nothing.

All configuration goes through a single write port: an address, a data word and a write strobe. The running count, both staged values, the update pulse and the flag are brought out as outputs.

Top module: `tmb_timebase`

## Requirements
- R1: After reset, count_o is 0, update_o is 0, flag_o is 0, psc_o is 0 and reload_o is RESET_RELOAD (0xFFFF by default). The run bit and the update-block bit both reset to 0.
- R2: While running, the counter advances once every P+1 clock cycles, where P is the active divide value. With active reload L, consecutive update pulses are therefore (L+1)*(P+1) cycles apart.
- R3: A write to address 4 (divide) or address 5 (reload) shows on psc_o or reload_o one cycle later. The counting rate and the wrap point do not change until the next update event.
- R4: On a counter advance with count_o at or above the active reload value, the counter becomes 0 and an update event occurs. Any other advance adds 1.
- R5: Writing 1 to bit 0 of address 1 while the update-block bit is 0 is a software update. It copies both staged values into their active copies, sets the counter and the divider to 0, and raises an update event.
- R6: While the update-block bit (bit 1 of address 0) is 1, a software update request changes nothing: the counter, the flag, update_o and the active values are all unaffected.
- R7: While the run bit (bit 0 of address 0) is 0, the counter and divider hold. The staged and active values are kept.
- R8: A write to address 3 loads the counter with wr_data in the following cycle. This takes priority over a counter advance in the same cycle.
- R9: flag_o is set by every update event and cleared by writing 1 to bit 0 of address 2. If an update event and a clear arrive in the same cycle, the flag ends up set.
- R10: update_o is high for exactly one cycle, in the cycle after each update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register select: 0 control, 1 update request, 2 flag clear, 3 count, 4 divide, 5 reload |
| wr_data | input | W | Write data |
| count_o | output | W | Current counter value |
| psc_o | output | W | Staged divide value |
| reload_o | output | W | Staged reload value |
| update_o | output | 1 | One-cycle update event pulse |
| flag_o | output | 1 | Sticky update flag |

## Verification
The hardest case to produce from the ports is a flag clear that lands in the same cycle as a counter wrap. The bench first loads a divide value of zero through a software update, so the counter advances on every cycle. It then watches count_o until it equals the reload value and issues the clear in that cycle, which is exactly the cycle of the wrap. Blocked software updates are exercised with the counter paused at a known value, so that any change in that value would be visible at the ports. A random stretch of writes then runs against a behavioural model that is compared on every clock.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_EVGEN  = 3'd1,
        REG_FLAG   = 3'd2,
        REG_COUNT  = 3'd3,
        REG_PSC    = 3'd4,
        REG_RELOAD = 3'd5
    } tmb_addr_e;

    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_BLOCK_BIT = 1;

    typedef struct packed {
        logic run;
        logic upd_block;
    } tmb_ctrl_t;

    function automatic logic hits(input logic we, input logic [2:0] addr, input tmb_addr_e target);
        return we && (tmb_addr_e'(addr) == target);
    endfunction
endpackage

// File: rtl/tmb_regfile.sv
module tmb_regfile
    import tmb_pkg::*;
#(
    parameter int W = 16,
    parameter logic [W-1:0] RESET_RELOAD = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         upd_evt,
    output tmb_ctrl_t    ctrl,
    output logic [W-1:0] psc_pre,
    output logic [W-1:0] arr_pre,
    output logic [W-1:0] psc_act,
    output logic [W-1:0] arr_act,
    output logic         sw_upd,
    output logic         cnt_wr,
    output logic         flag_clr
);
    logic unused_hi;
    assign unused_hi = ^wr_data[W-1:2];

    assign sw_upd   = hits(wr_en, wr_addr, REG_EVGEN) && wr_data[0] && !ctrl.upd_block;
    assign cnt_wr   = hits(wr_en, wr_addr, REG_COUNT);
    assign flag_clr = hits(wr_en, wr_addr, REG_FLAG) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            psc_pre <= '0;
            arr_pre <= RESET_RELOAD;
            psc_act <= '0;
            arr_act <= RESET_RELOAD;
        end else begin
            if (hits(wr_en, wr_addr, REG_CTRL)) begin
                ctrl.run       <= wr_data[CTRL_RUN_BIT];
                ctrl.upd_block <= wr_data[CTRL_BLOCK_BIT];
            end
            if (hits(wr_en, wr_addr, REG_PSC))    psc_pre <= wr_data;
            if (hits(wr_en, wr_addr, REG_RELOAD)) arr_pre <= wr_data;
            if (upd_evt) begin
                psc_act <= psc_pre;
                arr_act <= arr_pre;
            end
        end
    end

    // R3: active values move only with an update event
    a_r3_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_evt |=> ($stable(psc_act) && $stable(arr_act)));
    // R6: a blocked request never becomes a software update
    a_r6_block: assert property (@(posedge clk) disable iff (rst)
        ctrl.upd_block |-> !sw_upd);
endmodule

// File: rtl/tmb_prescaler.sv
module tmb_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] psc_act,
    output logic         tick
);
    logic [W-1:0] div_q;

    assign tick = run && (div_q == psc_act);

    always_ff @(posedge clk) begin
        if (rst || restart)  div_q <= '0;
        else if (tick)       div_q <= '0;
        else if (run)        div_q <= div_q + 1'b1;
    end

    // R7: divider frozen while stopped
    a_r7_div_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(div_q));
endmodule

// File: rtl/tmb_counter.sv
module tmb_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] arr_act,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    assign ovf = tick && (cnt >= arr_act);

    always_ff @(posedge clk) begin
        if (rst || clear)  cnt <= '0;
        else if (load)     cnt <= load_val;
        else if (ovf)      cnt <= '0;
        else if (tick)     cnt <= cnt + 1'b1;
    end

    // R4: a wrap returns the counter to zero
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (ovf && !load) |=> (cnt == '0));
    // R8: a direct load wins over counting
    a_r8_load: assert property (@(posedge clk) disable iff (rst)
        (load && !clear) |=> (cnt == $past(load_val)));
endmodule

// File: rtl/tmb_timebase.sv
module tmb_timebase
    import tmb_pkg::*;
#(
    parameter int W = 16,
    parameter logic [W-1:0] RESET_RELOAD = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count_o,
    output logic [W-1:0] psc_o,
    output logic [W-1:0] reload_o,
    output logic         update_o,
    output logic         flag_o
);
    tmb_ctrl_t    ctrl;
    logic [W-1:0] psc_act, arr_act;
    logic         sw_upd, cnt_wr, flag_clr, tick, ovf, upd_evt;

    assign upd_evt = sw_upd || ovf;

    tmb_regfile #(.W(W), .RESET_RELOAD(RESET_RELOAD)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .upd_evt(upd_evt), .ctrl(ctrl), .psc_pre(psc_o), .arr_pre(reload_o),
        .psc_act(psc_act), .arr_act(arr_act), .sw_upd(sw_upd), .cnt_wr(cnt_wr),
        .flag_clr(flag_clr)
    );

    tmb_prescaler #(.W(W)) u_psc (
        .clk(clk), .rst(rst), .run(ctrl.run), .restart(upd_evt),
        .psc_act(psc_act), .tick(tick)
    );

    tmb_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .clear(sw_upd), .load(cnt_wr),
        .load_val(wr_data), .arr_act(arr_act), .cnt(count_o), .ovf(ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            update_o <= 1'b0;
            flag_o   <= 1'b0;
        end else begin
            update_o <= upd_evt;
            if (upd_evt)       flag_o <= 1'b1;
            else if (flag_clr) flag_o <= 1'b0;
        end
    end

    // R9: an event always leaves the flag set
    a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
        upd_evt |=> flag_o);
    // R10: the update pulse lasts a single cycle unless a new event follows
    a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
        (update_o && !upd_evt) |=> !update_o);
    // R7: counter holds while stopped and untouched
    a_r7_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !cnt_wr && !sw_upd) |=> $stable(count_o));
endmodule

// File: tb/sim_tmb_timebase.sv
module sim_tmb_timebase;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count_o, psc_o, reload_o;
    logic update_o, flag_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference state
    int m_run, m_blk, m_pscp, m_arrp, m_psca, m_arra, m_div, m_cnt, m_upd, m_flag;

    tmb_timebase #(.W(W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count_o(count_o), .psc_o(psc_o), .reload_o(reload_o),
        .update_o(update_o), .flag_o(flag_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_blk = 0; m_pscp = 0; m_arrp = 16'hFFFF; m_psca = 0;
            m_arra = 16'hFFFF; m_div = 0; m_cnt = 0; m_upd = 0; m_flag = 0;
        end else begin
            int d, sw, tk, ov, ev, clr;
            d   = int'(wr_data);
            sw  = (wr_en && wr_addr == 3'd1 && d[0] && m_blk == 0) ? 1 : 0;
            tk  = (m_run != 0 && m_div == m_psca) ? 1 : 0;
            ov  = (tk != 0 && m_cnt >= m_arra) ? 1 : 0;
            ev  = sw | ov;
            clr = (wr_en && wr_addr == 3'd2 && d[0]) ? 1 : 0;
            if (ev != 0) begin m_psca = m_pscp; m_arra = m_arrp; end
            if (ev != 0 || tk != 0) m_div = 0;
            else if (m_run != 0) m_div = m_div + 1;
            if (sw != 0) m_cnt = 0;
            else if (wr_en && wr_addr == 3'd3) m_cnt = d;
            else if (ov != 0) m_cnt = 0;
            else if (tk != 0) m_cnt = (m_cnt + 1) & 16'hFFFF;
            m_upd = ev;
            if (ev != 0) m_flag = 1; else if (clr != 0) m_flag = 0;
            if (wr_en && wr_addr == 3'd0) begin m_run = d & 1; m_blk = (d >> 1) & 1; end
            if (wr_en && wr_addr == 3'd4) m_pscp = d;
            if (wr_en && wr_addr == 3'd5) m_arrp = d;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4 model count", int'(count_o), m_cnt);
            check("R10 model update", int'(update_o), m_upd);
            check("R9 model flag", int'(flag_o), m_flag);
            check("R3 model divide readback", int'(psc_o), m_pscp);
            check("R3 model reload readback", int'(reload_o), m_arrp);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic period(output int n);
        int k = 0;
        while (!update_o && k < 500) begin @(negedge clk); k++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!update_o && n < 500);
    endtask

    initial begin
        int p, c, k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 count", int'(count_o), 0);
        check("R1 update", int'(update_o), 0);
        check("R1 flag", int'(flag_o), 0);
        check("R1 divide", int'(psc_o), 0);
        check("R1 reload", int'(reload_o), 16'hFFFF);

        wr(5, 4);
        check("R3 reload readback", int'(reload_o), 4);
        wr(1, 1);
        check("R5 update pulse", int'(update_o), 1);
        check("R5 flag set", int'(flag_o), 1);
        @(negedge clk);
        check("R10 single pulse", int'(update_o), 0);
        wr(2, 1);
        check("R9 flag clear", int'(flag_o), 0);
        wr(0, 1);
        period(p);
        check("R4 period reload 4", p, 5);
        wr(4, 2);
        check("R3 divide readback", int'(psc_o), 2);
        period(p);
        check("R2 period divide 2", p, 15);

        wr(0, 0);
        c = int'(count_o);
        repeat (10) @(negedge clk);
        check("R7 count held", int'(count_o), c);
        check("R7 divide kept", int'(psc_o), 2);
        check("R7 reload kept", int'(reload_o), 4);

        wr(3, 2);
        check("R8 count load", int'(count_o), 2);
        wr(2, 1);
        wr(0, 2);
        wr(1, 1);
        check("R6 blocked count", int'(count_o), 2);
        check("R6 blocked pulse", int'(update_o), 0);
        check("R6 blocked flag", int'(flag_o), 0);
        wr(0, 0);
        wr(1, 1);
        check("R5 count reset", int'(count_o), 0);
        check("R5 update pulse", int'(update_o), 1);

        wr(4, 0);
        wr(1, 1);
        wr(3, 10);
        wr(2, 1);
        wr(0, 1);
        check("R4 above reload before", int'(count_o), 10);
        @(negedge clk);
        check("R4 above reload wraps", int'(count_o), 0);
        check("R4 above reload event", int'(update_o), 1);

        k = 0;
        while (count_o != 1 && k < 50) begin @(negedge clk); k++; end
        wr(2, 1);
        check("R9 cleared before race", int'(flag_o), 0);
        k = 0;
        while (count_o != 4 && k < 50) begin @(negedge clk); k++; end
        wr(2, 1);
        check("R9 set wins over clear", int'(flag_o), 1);
        check("R4 wrap at reload", int'(count_o), 0);

        for (int i = 0; i < 400; i++) begin
            int a, d;
            a = int'($urandom % 6);
            d = int'($urandom);
            case (a)
                3: d = d & 31;
                4: d = d & 3;
                5: d = d & 15;
                default: d = d & 3;
            endcase
            if (($urandom % 3) == 0) wr(a, d);
            else @(negedge clk);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule